// File: doc/BRIEF.md
# Serial Ethernet Transmit Framer

This block turns a frame payload, delivered as a byte stream with valid and last markers, into a serial bit stream on a single data line. The line carries one bit per clock. Each frame opens with seven preamble bytes of 0x55 and one start-of-frame delimiter byte of 0xD5. The payload follows. Zero bytes are then added when the data field is shorter than the minimum length. A 32-bit CRC closes the frame. Every byte goes out least significant bit first. A transmit-enable output stays high for the whole frame.

Two per-frame control inputs can switch off the zero padding and the CRC trailer. They are captured in the cycle the frame starts. The payload is pulled from the source with a one-cycle ready strobe, issued exactly when the serialiser needs the next data byte. While preamble, padding or CRC bits go out, ready stays low. A busy output covers the whole frame. A one-cycle done pulse marks the end of each frame.

The controller is a seven-state machine:

| State | Action | Next state |
|---|---|---|
| IDLE | Waits for the source to present a byte | PRE, the cycle after `in_valid` is seen |
| PRE | Sends the preamble bytes | SFD, after the seventh preamble byte |
| SFD | Sends the delimiter byte | DATA; the first payload byte is taken at the delimiter's last bit |
| DATA | Sends payload bytes | DATA, while more bytes follow; otherwise PAD, FCS or DONE |
| PAD | Sends zero bytes | PAD, until the data field reaches the minimum; otherwise FCS or DONE |
| FCS | Sends the four CRC bytes | DONE, after the fourth byte |
| DONE | Holds for one cycle | IDLE, unconditionally |

From DATA, the machine moves to PAD when padding is enabled and the data field is still short. Otherwise it moves to FCS when the CRC is enabled. Otherwise it moves to DONE.

Top module: `sertx_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_en`, `tx_d`, `busy`, `in_ready` and `done` are all 0.
- R2: When `in_valid` is 1 at a clock edge while idle, `tx_en` rises in the next cycle together with the first preamble bit. The first 64 bits are seven 0x55 bytes and then 0xD5. Bits go out LSB first, so the delimiter appears as 1,0,1,0,1,0,1,1.
- R3: Data bytes go out in arrival order, LSB first, one bit per cycle. `in_ready` is 1 only in the last-bit cycle of the delimiter and of each data byte not marked `in_last`. The byte on `in_data` is taken at that edge.
- R4: When padding is enabled and fewer than 46 data bytes were sent, 0x00 bytes follow the data until the data field holds 46 bytes.
- R5: When `no_pad` is 1 at frame start, no zero bytes are added, whatever the payload length.
- R6: When the CRC is enabled, four bytes follow the data field. They hold the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, result inverted) over data and pad bytes, sent low byte first and LSB first.
- R7: When `no_fcs` is 1 at frame start, the frame ends after the last data or pad bit.
- R8: `tx_en` stays 1 from the first preamble bit to the last frame bit. In the next cycle `tx_en` is 0 and `done` pulses for one cycle. `busy` is 1 from the first preamble cycle through the done cycle. The block is idle in the cycle after done.
- R9: `no_pad` and `no_fcs` are sampled only in the frame-start cycle. Changes to them during the frame have no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte present; starts a frame when idle |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Byte on `in_data` is taken at this edge |
| no_pad | input | 1 | Suppress zero padding for this frame |
| no_fcs | input | 1 | Suppress the CRC trailer for this frame |
| tx_en | output | 1 | Transmit enable |
| tx_d | output | 1 | Serial data line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume the source never lets a payload underrun occur. Once a frame has started, `in_valid` must be high whenever `in_ready` strobes, because the wire cannot pause for data. The bench keeps `in_valid` high from the first byte until the last byte is taken, and it only changes `in_data` on the falling edge after a strobe. The bench starts a new frame only after the previous done pulse. The bench also toggles the control inputs in the middle of some frames, which stays within the rule that they are sampled only at frame start.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_DONE
    } tx_state_e;

    localparam logic [7:0]  PRE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE = 8'hD5;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

endpackage

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              run,
    output logic              ser_bit,
    output logic              last_bit
);
    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    logic [BYTE_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            idx_q <= '0;
        end else if (run) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign ser_bit  = sh_q[0];
    assign last_bit = (idx_q == IDX_W'(BYTE_W - 1));
endmodule

// File: rtl/sertx_crc.sv
module sertx_crc #(
    parameter int              CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_next
);
    logic [CRC_W-1:0] crc_q;

    always_comb begin
        crc_next = crc_q;
        if (shift) begin
            crc_next = (crc_q >> 1) ^ (((crc_q[0] ^ bit_in) == 1'b1) ? POLY : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= '1;
        end else begin
            crc_q <= crc_next;
        end
    end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int PRE_BYTES = 7,
    parameter int MIN_DATA  = 46
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       no_pad,
    input  logic       no_fcs,
    output logic       tx_en,
    output logic       tx_d,
    output logic       busy,
    output logic       done
);
    localparam int CRC_W     = 32;
    localparam int FCS_BYTES = CRC_W / 8;
    localparam int PRE_W     = (PRE_BYTES > 1) ? $clog2(PRE_BYTES) : 1;
    localparam int DCNT_W    = $clog2(MIN_DATA + 1);
    localparam int FIDX_W    = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

    tx_state_e         state_q, state_d;
    logic [PRE_W-1:0]  pre_cnt_q;
    logic [DCNT_W-1:0] dat_cnt_q;
    logic [FIDX_W-1:0] fcs_idx_q;
    logic [CRC_W-1:0]  fcs_word_q;
    logic              last_seen_q, keep_pad_q, keep_fcs_q;

    logic              ld;
    logic [7:0]        ld_val;
    logic              take;
    logic              crc_clr;
    logic              ser_bit, last_bit, active;
    logic [CRC_W-1:0]  crc_next;
    logic              need_pad;

    sertx_shifter #(.BYTE_W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .run      (active),
        .ser_bit  (ser_bit),
        .last_bit (last_bit)
    );

    sertx_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (crc_clr),
        .shift    (state_q == ST_DATA || state_q == ST_PAD),
        .bit_in   (ser_bit),
        .crc_next (crc_next)
    );

    assign need_pad = keep_pad_q && (dat_cnt_q < DCNT_W'(MIN_DATA));

    // Next-state and byte-load selection
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        take    = 1'b0;
        crc_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = ST_PRE;
                    ld      = 1'b1;
                    ld_val  = PRE_BYTE;
                    crc_clr = 1'b1;
                end
            end
            ST_PRE: begin
                if (last_bit) begin
                    ld = 1'b1;
                    if (pre_cnt_q == PRE_W'(PRE_BYTES - 1)) begin
                        state_d = ST_SFD;
                        ld_val  = SFD_BYTE;
                    end else begin
                        ld_val  = PRE_BYTE;
                    end
                end
            end
            ST_SFD: begin
                if (last_bit) begin
                    take    = 1'b1;
                    ld      = 1'b1;
                    ld_val  = in_data;
                    state_d = ST_DATA;
                end
            end
            ST_DATA, ST_PAD: begin
                if (last_bit) begin
                    if (state_q == ST_DATA && !last_seen_q) begin
                        take   = 1'b1;
                        ld     = 1'b1;
                        ld_val = in_data;
                    end else if (need_pad) begin
                        state_d = ST_PAD;
                        ld      = 1'b1;
                        ld_val  = 8'h00;
                    end else if (keep_fcs_q) begin
                        state_d = ST_FCS;
                        ld      = 1'b1;
                        ld_val  = ~crc_next[7:0];
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_FCS: begin
                if (last_bit) begin
                    if (fcs_idx_q == FIDX_W'(FCS_BYTES - 1)) begin
                        state_d = ST_DONE;
                    end else begin
                        ld     = 1'b1;
                        ld_val = fcs_word_q[15:8];
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pre_cnt_q   <= '0;
            dat_cnt_q   <= '0;
            fcs_idx_q   <= '0;
            fcs_word_q  <= '0;
            last_seen_q <= 1'b0;
            keep_pad_q  <= 1'b0;
            keep_fcs_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && in_valid) begin
                pre_cnt_q   <= '0;
                dat_cnt_q   <= '0;
                last_seen_q <= 1'b0;
                keep_pad_q  <= !no_pad;
                keep_fcs_q  <= !no_fcs;
            end
            if (state_q == ST_PRE && ld) begin
                pre_cnt_q <= pre_cnt_q + PRE_W'(1);
            end
            if (ld && (state_d == ST_DATA || state_d == ST_PAD)
                    && dat_cnt_q != DCNT_W'(MIN_DATA)) begin
                dat_cnt_q <= dat_cnt_q + DCNT_W'(1);
            end
            if (take) begin
                last_seen_q <= in_last;
            end
            if (state_q != ST_FCS && state_d == ST_FCS) begin
                fcs_word_q <= ~crc_next;
                fcs_idx_q  <= '0;
            end else if (state_q == ST_FCS && ld) begin
                fcs_word_q <= fcs_word_q >> 8;
                fcs_idx_q  <= fcs_idx_q + FIDX_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        active   = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:                                 busy   = 1'b0;
            ST_PRE, ST_SFD, ST_DATA, ST_PAD, ST_FCS: active = 1'b1;
            ST_DONE:                                 done   = 1'b1;
            default:                                 busy   = 1'b0;
        endcase
        tx_en    = active;
        tx_d     = active & ser_bit;
        in_ready = take;
    end
endmodule

module sertx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic tx_en,
    input logic busy,
    input logic done
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_en && !in_ready && !done));

    assert_start_on_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> ($past(in_valid) && $past(!busy)));

    assert_ready_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (tx_en && busy));

    assert_no_underrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_valid);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!tx_en && $past(tx_en)));

    assert_txen_ends_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> done);
endmodule

bind sertx_framer sertx_framer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_en    (tx_en),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_sertx_framer.sv
module tb_sertx_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       no_pad = 1'b0;
    logic       no_fcs = 1'b0;
    logic       tx_en, tx_d, busy, done;

    always #2 clk = ~clk;

    sertx_framer dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .no_pad(no_pad), .no_fcs(no_fcs),
        .tx_en(tx_en), .tx_d(tx_d), .busy(busy), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    bit exp_q[$];
    int m_st  = 0;   // 0 idle, 1 sending, 2 done cycle
    int m_pos = 0;
    int m_n = 0, m_dend = 0, m_pend = 0;
    bit m_np = 0, m_nf = 0, m_flip = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input byte unsigned b[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (b[i]) begin
            for (int j = 0; j < 8; j++) begin
                if ((c[0] ^ b[i][j]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
                else                          c = c >> 1;
            end
        end
        return ~c;
    endfunction

    function automatic string tag_for(input int pos);
        if (m_flip)              return "R9";
        if (pos < 64)            return "R2";
        if (pos < m_dend)        return "R3";
        if (m_np)                return "R5";
        if (pos < m_pend)        return "R4";
        return "R6";
    endfunction

    // Reference model, compared every clock
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && !finished) begin
                case (m_st)
                    0: if (in_valid) begin m_st = 1; m_pos = 0; end
                    1: if (m_pos == exp_q.size()) m_st = 2;
                    default: m_st = 0;
                endcase
                if (m_st == 1) begin
                    automatic int  byi = m_pos / 8;
                    automatic bit  rdy = (m_pos % 8 == 7) && (byi >= 7) && (byi <= 7 + m_n - 1);
                    chk(tx_en == 1'b1, "R8", "tx_en in frame", tx_en, 1);
                    chk(tx_d == exp_q[m_pos], tag_for(m_pos), $sformatf("bit %0d", m_pos), tx_d, exp_q[m_pos]);
                    chk(in_ready == rdy, "R3", $sformatf("in_ready at bit %0d", m_pos), in_ready, rdy);
                    chk(busy == 1'b1 && done == 1'b0, "R8", "busy/done in frame", {busy, done}, 2);
                    m_pos++;
                end else if (m_st == 2) begin
                    chk(tx_en == 1'b0, m_nf ? "R7" : "R8", "tx_en after last bit", tx_en, 0);
                    chk(done == 1'b1 && busy == 1'b1, "R8", "done pulse", {busy, done}, 3);
                end else begin
                    chk(!tx_en && !tx_d && !busy && !done && !in_ready, "R1", "idle outputs",
                        {tx_en, tx_d, busy, done, in_ready}, 0);
                end
            end
        end
    end

    task automatic send_frame(input int n, input bit np, input bit nf, input bit flip);
        byte unsigned pl[$];
        byte unsigned crc_in[$];
        logic [31:0] c;
        int padn;
        for (int i = 0; i < n; i++) pl.push_back(8'((i * 37 + n * 11 + 5) & 255));
        wait (m_st == 0);
        @(negedge clk);
        exp_q.delete();
        for (int k = 0; k < 7; k++)
            for (int j = 0; j < 8; j++) exp_q.push_back(((8'h55 >> j) & 1) != 0);
        for (int j = 0; j < 8; j++) exp_q.push_back(((8'hD5 >> j) & 1) != 0);
        crc_in = pl;
        padn = (!np && n < 46) ? 46 - n : 0;
        for (int k = 0; k < padn; k++) crc_in.push_back(8'h00);
        foreach (crc_in[i])
            for (int j = 0; j < 8; j++) exp_q.push_back(crc_in[i][j]);
        if (!nf) begin
            c = ref_crc(crc_in);
            for (int j = 0; j < 32; j++) exp_q.push_back(c[j]);
        end
        m_n = n; m_dend = 64 + 8 * n; m_pend = m_dend + 8 * padn;
        m_np = np; m_nf = nf; m_flip = flip;
        no_pad = np; no_fcs = nf;
        for (int i = 0; i < n; i++) begin
            in_data  = pl[i];
            in_last  = (i == n - 1);
            in_valid = 1'b1;
            if (flip && i == 1) begin no_pad = !np; no_fcs = !nf; end
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        byte unsigned v[$];
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!tx_en && !busy && !done && !in_ready && !tx_d, "R1", "reset outputs",
            {tx_en, busy, done, in_ready, tx_d}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!tx_en && !busy && !done && !in_ready, "R1", "idle after reset",
            {tx_en, busy, done, in_ready}, 0);
        v = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        chk(ref_crc(v) == 32'hCBF43926, "R6", "bench CRC check value", 0, 0);

        send_frame(1, 0, 0, 0);   // R4 heavy padding, R6
        send_frame(46, 0, 0, 0);  // R4 exact minimum, no pad
        send_frame(45, 0, 0, 0);  // R4 single pad byte
        send_frame(60, 0, 0, 0);  // R3 long payload
        send_frame(10, 1, 0, 0);  // R5
        send_frame(10, 0, 1, 0);  // R7 pad then end
        send_frame(5, 1, 1, 0);   // R5 and R7 together
        send_frame(20, 1, 0, 1);  // R9 flags flipped mid-frame
        send_frame(3, 0, 1, 1);   // R9
        send_frame(2, 0, 0, 0);   // back-to-back start
        send_frame(2, 0, 0, 0);
        wait (m_st == 0);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule